// File: doc/BRIEF.md
# Dual-Die Interleaved Page-Program Scheduler

This block drives page-program operations onto two NAND dies that share one 8-bit write bus. Each die has its own active-low chip enable and its own ready/busy line. Requests arrive one at a time through a valid/ready handshake, each carrying a row (page) address. The lowest bit of that address selects the die. For every accepted request the block sends the full program frame: the setup command, the column and row address cycles, the page data pulled byte by byte from a source port, and the confirm command. After the confirm the die starts its internal program, and the block drops that die's chip enable for the whole busy time.

While one die is busy programming, the bus is free. A request for the other die is loaded straight away, so the program time of one die overlaps the loading of the other. Requests are served strictly in order. When the head request targets a busy die, it waits, even if the other die is idle. When a die's ready/busy line rises after one of its programs, the block raises a one-cycle completion pulse on that die's lane, together with the page that finished.

After reset the block keeps both chip enables high until both ready lines read ready. It then sends a reset command to die 0 and after that to die 1. Only then does it accept program requests.

Top module: `dual_die_prog_sched`

## Requirements
- R1: After reset, both chip enables stay high and no write strobe occurs until both ready/busy inputs are high. The first two bus cycles are then the reset command 0xFF with CLE high, to die 0 first and to die 1 second. No program request is accepted before both of these have gone out.
- R2: A program frame uses one clock per byte with the write strobe low, in this order: 0x80 with CLE; COL_BYTES zero bytes with ALE; the row address with ALE, least significant byte first, over ceil(ROW_W/8) bytes; PAGE_BYTES data bytes with CLE and ALE low; and 0x10 with CLE. CLE and ALE are never high together.
- R3: A request goes to die 0 when bit 0 of its page address is 0 and to die 1 when that bit is 1. Its frame starts in the clock cycle after the handshake.
- R4: Requests are loaded in arrival order. req_ready stays low while the head request's die is busy or has not yet been seen to go busy and come back, whatever the state of the other die.
- R5: A request to a ready die is accepted and loaded while the other die is busy programming.
- R6: Outside its own bus cycles a die's chip enable is high. This includes the whole of its internal busy time.
- R7: The two chip enables are never low in the same cycle.
- R8: Each finished program gives exactly one one-cycle pulse on its die's completion lane, with that request's page. The pulse comes after the die's ready/busy line rises following the confirm. A reset command produces no pulse.
- R9: src_rd is high exactly in the data cycles of a frame, and the byte on src_byte in that cycle is the byte driven onto the bus.
- R10: No bus cycle is ever addressed to a die whose ready/busy input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A page-program request is offered |
| req_ready | output | 1 | The request is accepted this cycle |
| req_page | input | ROW_W | Row address; bit 0 selects the die |
| src_rd | output | 1 | Data byte taken from src_byte this cycle |
| src_byte | input | 8 | Next data byte of the page being loaded |
| nand_ce_n | output | 2 | Active-low chip enable per die |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe, one byte per low cycle |
| nand_io | output | 8 | Shared bus byte |
| nand_rb | input | 2 | Ready/busy per die, high = ready |
| cpl_valid | output | 2 | One-cycle completion pulse per die |
| cpl_page | output | 2*ROW_W | Finished page per die, die 1 in the upper half |

## Verification
The bench models both dies with a program time that depends on the page. It runs three request patterns: a same-die pair followed by an other-die request, which tests head-of-line blocking; a strictly alternating run, which tests overlap; and a pseudo-random run. A scheduler that skipped ahead to the idle die would load the third request early and fail the frame-order and ready checks. One that ignored the busy window right after a confirm would write to a busy die. Every bus byte is compared with a frame computed from the accepted page, so a wrong address byte order, a wrong data count or a missing confirm shows up at the failing byte. Completion pulses are matched one-to-one against ready rises after programs. This catches a lost, doubled or reset-triggered pulse, or a pulse carrying the wrong page.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  localparam logic [7:0] OP_PROG_SETUP = 8'h80;
  localparam logic [7:0] OP_PROG_CONF  = 8'h10;
  localparam logic [7:0] OP_RESET      = 8'hFF;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_ADDR, PH_DATA, PH_CONF, PH_RST
  } bus_phase_e;

  typedef enum logic [1:0] {
    DS_READY, DS_WAIT_FALL, DS_BUSY
  } die_state_e;

  typedef enum logic [1:0] {
    CS_WAIT_RB, CS_RST_D0, CS_RST_D1, CS_RUN
  } ctrl_state_e;
endpackage

// File: rtl/nfs_rb_sync.sv
module nfs_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr_q[0] <= 1'b0;
          else        sr_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr_q[s] <= 1'b0;
          else        sr_q[s] <= sr_q[s-1];
        end
      end
    end
  endgenerate

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/nfs_die_track.sv
module nfs_die_track
  import nfs_pkg::*;
#(
  parameter int ROW_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rb_s,
  input  logic             issue_prog,
  input  logic             issue_rst,
  input  logic [ROW_W-1:0] page_in,
  output logic             ready,
  output logic             cpl,
  output logic [ROW_W-1:0] cpl_page
);
  die_state_e       st_q, st_d;
  logic             prog_q, prog_d;
  logic [ROW_W-1:0] page_q;
  logic             page_en;

  always_comb begin
    st_d    = st_q;
    prog_d  = prog_q;
    page_en = 1'b0;
    cpl     = 1'b0;
    unique case (st_q)
      DS_READY: begin
        if (issue_prog || issue_rst) begin
          st_d    = DS_WAIT_FALL;
          prog_d  = issue_prog;
          page_en = issue_prog;
        end
      end
      DS_WAIT_FALL: begin
        if (!rb_s) st_d = DS_BUSY;
      end
      DS_BUSY: begin
        if (rb_s) begin
          st_d   = DS_READY;
          cpl    = prog_q;
          prog_d = 1'b0;
        end
      end
      default: st_d = DS_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DS_READY;
      prog_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      prog_q <= prog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_en) page_q <= page_in;
  end

  assign ready    = (st_q == DS_READY);
  assign cpl_page = page_q;
endmodule

// File: rtl/nfs_bus_seq.sv
module nfs_bus_seq
  import nfs_pkg::*;
#(
  parameter int ROW_W      = 24,
  parameter int COL_BYTES  = 2,
  parameter int PAGE_BYTES = 2112
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_prog,
  input  logic             start_rst,
  input  logic             die_in,
  input  logic [ROW_W-1:0] page_in,
  input  logic [7:0]       src_byte,
  output logic [1:0]       ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic [7:0]       io,
  output logic             src_rd,
  output logic             idle,
  output logic             confirm,
  output logic             rst_cmd,
  output logic             cur_die,
  output logic [ROW_W-1:0] cur_page
);
  localparam int ROW_BYTES = (ROW_W + 7) / 8;
  localparam int ADDR_N    = COL_BYTES + ROW_BYTES;
  localparam int MAXN      = (PAGE_BYTES > ADDR_N) ? PAGE_BYTES : ADDR_N;
  localparam int CNT_W     = $clog2(MAXN + 1);

  bus_phase_e           ph_q, ph_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 die_q;
  logic [ROW_W-1:0]     page_q;
  logic                 load_en;
  logic [8*ROW_BYTES-1:0] row_pad;
  logic [7:0]           addr_byte;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_prog) begin
          ph_d    = PH_SETUP;
          load_en = 1'b1;
        end else if (start_rst) begin
          ph_d    = PH_RST;
          load_en = 1'b1;
        end
      end
      PH_SETUP: begin
        ph_d  = PH_ADDR;
        cnt_d = '0;
      end
      PH_ADDR: begin
        if (cnt_q == CNT_W'(ADDR_N - 1)) begin
          ph_d  = PH_DATA;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DATA: begin
        if (cnt_q == CNT_W'(PAGE_BYTES - 1)) begin
          ph_d  = PH_CONF;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_CONF: ph_d = PH_IDLE;
      PH_RST:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      die_q  <= 1'b0;
      page_q <= '0;
    end else if (load_en) begin
      die_q  <= die_in;
      page_q <= start_prog ? page_in : page_q;
    end
  end

  assign row_pad = {{(8*ROW_BYTES-ROW_W){1'b0}}, page_q};

  always_comb begin
    addr_byte = 8'h00;
    for (int b = 0; b < ROW_BYTES; b++) begin
      if (cnt_q == CNT_W'(COL_BYTES + b)) addr_byte = row_pad[8*b +: 8];
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_SETUP: io = OP_PROG_SETUP;
      PH_ADDR:  io = addr_byte;
      PH_DATA:  io = src_byte;
      PH_CONF:  io = OP_PROG_CONF;
      PH_RST:   io = OP_RESET;
      default:  io = 8'h00;
    endcase
  end

  assign idle     = (ph_q == PH_IDLE);
  assign we_n     = idle;
  assign ce_n     = idle ? 2'b11 : (die_q ? 2'b01 : 2'b10);
  assign cle      = (ph_q == PH_SETUP) || (ph_q == PH_CONF) || (ph_q == PH_RST);
  assign ale      = (ph_q == PH_ADDR);
  assign src_rd   = (ph_q == PH_DATA);
  assign confirm  = (ph_q == PH_CONF);
  assign rst_cmd  = (ph_q == PH_RST);
  assign cur_die  = die_q;
  assign cur_page = page_q;
endmodule

// File: rtl/dual_die_prog_sched.sv
module dual_die_prog_sched
  import nfs_pkg::*;
#(
  parameter int ROW_W       = 24,
  parameter int COL_BYTES   = 2,
  parameter int PAGE_BYTES  = 2112,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ROW_W-1:0]   req_page,
  output logic               src_rd,
  input  logic [7:0]         src_byte,
  output logic [1:0]         nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic [7:0]         nand_io,
  input  logic [1:0]         nand_rb,
  output logic [1:0]         cpl_valid,
  output logic [2*ROW_W-1:0] cpl_page
);
  localparam int NDIE = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic [NDIE-1:0]  rb_s, die_rdy, iss_prog, iss_rst;
  ctrl_state_e      cs_q, cs_d;
  logic             start_prog, start_rst, start_die;
  logic             seq_idle, seq_conf, seq_rst, seq_die;
  logic [ROW_W-1:0] seq_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  genvar d;
  generate
    for (d = 0; d < NDIE; d++) begin : g_die
      nfs_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n_i), .d(nand_rb[d]), .q(rb_s[d])
      );
      assign iss_prog[d] = seq_conf && (seq_die == 1'(d));
      assign iss_rst[d]  = seq_rst  && (seq_die == 1'(d));
      nfs_die_track #(.ROW_W(ROW_W)) u_track (
        .clk(clk), .rst_n(rst_n_i), .rb_s(rb_s[d]),
        .issue_prog(iss_prog[d]), .issue_rst(iss_rst[d]),
        .page_in(seq_page), .ready(die_rdy[d]),
        .cpl(cpl_valid[d]), .cpl_page(cpl_page[d*ROW_W +: ROW_W])
      );
    end
  endgenerate

  always_comb begin
    cs_d      = cs_q;
    start_rst = 1'b0;
    start_die = 1'b0;
    unique case (cs_q)
      CS_WAIT_RB: if (&rb_s) cs_d = CS_RST_D0;
      CS_RST_D0: begin
        if (seq_idle) begin
          start_rst = 1'b1;
          cs_d      = CS_RST_D1;
        end
      end
      CS_RST_D1: begin
        if (seq_idle) begin
          start_rst = 1'b1;
          start_die = 1'b1;
          cs_d      = CS_RUN;
        end
      end
      CS_RUN:  cs_d = CS_RUN;
      default: cs_d = CS_WAIT_RB;
    endcase
    if (cs_q == CS_RUN) start_die = req_page[0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) cs_q <= CS_WAIT_RB;
    else          cs_q <= cs_d;
  end

  assign req_ready  = (cs_q == CS_RUN) && seq_idle && die_rdy[req_page[0]];
  assign start_prog = req_valid && req_ready;

  nfs_bus_seq #(
    .ROW_W(ROW_W), .COL_BYTES(COL_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_i),
    .start_prog(start_prog), .start_rst(start_rst),
    .die_in(start_die), .page_in(req_page), .src_byte(src_byte),
    .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .io(nand_io), .src_rd(src_rd), .idle(seq_idle), .confirm(seq_conf),
    .rst_cmd(seq_rst), .cur_die(seq_die), .cur_page(seq_page)
  );
endmodule

// File: rtl/nfs_sched_chk.sv
module nfs_sched_chk #(
  parameter int ROW_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [ROW_W-1:0] req_page,
  input logic             src_rd,
  input logic [1:0]       nand_ce_n,
  input logic             nand_cle,
  input logic             nand_ale,
  input logic             nand_we_n,
  input logic [7:0]       nand_io,
  input logic [1:0]       nand_rb,
  input logic [1:0]       cpl_valid
);
  AST_CE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_ce_n == 2'b00)); // R7

  AST_CE_HIGH_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    nand_we_n |-> (nand_ce_n == 2'b11)); // R6

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R2

  AST_SRC_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |-> (!nand_we_n && !nand_cle && !nand_ale)); // R9

  AST_NO_WRITE_BUSY0: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !nand_ce_n[0]) |-> nand_rb[0]); // R10

  AST_NO_WRITE_BUSY1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !nand_ce_n[1]) |-> nand_rb[1]); // R10

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!nand_we_n && nand_cle && nand_io == 8'h80 &&
       !nand_ce_n[$past(req_page[0])])); // R3

  AST_CPL_PULSE0: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid[0] |=> !cpl_valid[0]); // R8

  AST_CPL_PULSE1: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid[1] |=> !cpl_valid[1]); // R8
endmodule

bind dual_die_prog_sched nfs_sched_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_page(req_page), .src_rd(src_rd), .nand_ce_n(nand_ce_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_io(nand_io), .nand_rb(nand_rb), .cpl_valid(cpl_valid)
);

// File: tb/dual_die_prog_sched_bench.sv
`timescale 1ns/1ps
module dual_die_prog_sched_bench;
  localparam int ROW_W = 16, COLB = 2, PB = 5, ROWB = 2, ADDR_N = COLB + ROWB;
  localparam int NREQ = 31;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [ROW_W-1:0] req_page = '0;
  logic src_rd;
  logic [7:0] src_byte;
  logic [1:0] nand_ce_n;
  logic nand_cle, nand_ale, nand_we_n;
  logic [7:0] nand_io;
  logic [1:0] rb_q = 2'b00;
  logic [1:0] cpl_valid;
  logic [2*ROW_W-1:0] cpl_page;

  int checks = 0, errors = 0;
  int dly[2], bsy[2], pos[2];
  bit prog_flag[2], exp_pend[2];
  logic [ROW_W-1:0] exp_page[2];
  int rst_cnt = 0, cpl_cnt = 0, overlap = 0, frames = 0;
  bit hold = 1, done = 0;
  logic [ROW_W-1:0] cur_page = '0;
  int src_idx = 0;
  logic [ROW_W-1:0] reqs[NREQ];

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [ROW_W-1:0] p, input int k);
    return 8'(p[7:0] * 8'd7 + 8'(k) * 8'd29 + p[15:8]);
  endfunction

  assign src_byte = pat(cur_page, src_idx);

  dual_die_prog_sched #(.ROW_W(ROW_W), .COL_BYTES(COLB), .PAGE_BYTES(PB),
    .SYNC_STAGES(2)) u_dual_die_prog_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .src_rd(src_rd), .src_byte(src_byte),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_io(nand_io), .nand_rb(rb_q),
    .cpl_valid(cpl_valid), .cpl_page(cpl_page));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // die models, source index and bus checks, all sampled at the falling edge
  always @(negedge clk) if (rst_n) begin
    if (hold) chk(nand_we_n && nand_ce_n == 2'b11, "R1 quiet while busy", nand_ce_n, 3);
    if (nand_we_n) chk(nand_ce_n == 2'b11, "R6 ce high off bus", nand_ce_n, 3);
    else begin
      chk(nand_ce_n != 2'b00, "R7 single ce", nand_ce_n, 1);
      for (int d = 0; d < 2; d++) if (!nand_ce_n[d]) begin
        chk(rb_q[d] && dly[d] == 0, "R10 write to busy die", rb_q[d], 1);
        if (pos[d] == 0) begin
          if (nand_cle && nand_io == 8'hFF) begin
            chk(rst_cnt == d, "R1 reset order", rst_cnt, d);
            rst_cnt++;
            dly[d] = 2; bsy[d] = 3;
          end else begin
            chk(nand_cle && nand_io == 8'h80, "R2 setup", nand_io, 8'h80);
            chk(rst_cnt == 2, "R1 program after resets", rst_cnt, 2);
            chk(cur_page[0] == d, "R3 die select", d, cur_page[0]);
            if (!rb_q[1-d] || dly[1-d] != 0) overlap++;
            frames++;
            src_idx = 0;
            pos[d] = 1;
          end
        end else if (pos[d] <= ADDR_N) begin
          logic [7:0] e;
          int i;
          i = pos[d] - 1;
          e = (i < COLB) ? 8'h00 : cur_page[8*(i-COLB) +: 8];
          chk(nand_ale && !nand_cle && nand_io == e, "R2 address byte", nand_io, e);
          pos[d]++;
        end else if (pos[d] <= ADDR_N + PB) begin
          chk(src_rd && !nand_ale && !nand_cle, "R9 data strobe", src_rd, 1);
          chk(nand_io == pat(cur_page, src_idx), "R2 data byte", nand_io, pat(cur_page, src_idx));
          src_idx++;
          pos[d]++;
        end else begin
          chk(nand_cle && nand_io == 8'h10, "R2 confirm", nand_io, 8'h10);
          pos[d] = 0;
          prog_flag[d] = 1; exp_page[d] = cur_page;
          dly[d] = 2; bsy[d] = 12 + 3 * (cur_page % 7);
        end
      end
    end
    if (nand_we_n) chk(!src_rd, "R9 no strobe idle", src_rd, 0);
    // R4: head request must wait while its die is not ready
    if (req_valid && (!rb_q[req_page[0]] || dly[req_page[0]] != 0))
      chk(!req_ready, "R4 head waits for busy die", req_ready, 0);
    for (int d = 0; d < 2; d++) begin
      if (cpl_valid[d]) begin
        chk(exp_pend[d], "R8 unexpected completion", d, 0);
        chk(cpl_page[d*ROW_W +: ROW_W] == exp_page[d], "R8 completion page",
            cpl_page[d*ROW_W +: ROW_W], exp_page[d]);
        exp_pend[d] = 0;
        cpl_cnt++;
      end
      if (dly[d] > 0) begin
        dly[d]--;
        if (dly[d] == 0) rb_q[d] = 1'b0;
      end else if (!rb_q[d] && bsy[d] > 0) begin
        bsy[d]--;
        if (bsy[d] == 0) begin
          rb_q[d] = 1'b1;
          if (prog_flag[d]) begin
            chk(!exp_pend[d], "R8 missed completion", exp_pend[d], 0);
            exp_pend[d] = 1; prog_flag[d] = 0;
          end
        end
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int d = 0; d < 2; d++) begin
      dly[d] = 0; bsy[d] = 0; pos[d] = 0; prog_flag[d] = 0; exp_pend[d] = 0;
    end
    // same-die pair then other die (R4), alternating run (R5), pseudo-random
    reqs[0] = 16'h0002; reqs[1] = 16'h0004; reqs[2] = 16'h0001;
    for (int i = 0; i < 10; i++) reqs[3+i] = 16'(16'h1230 + i);
    lfsr = 16'hACE1;
    for (int i = 13; i < NREQ; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reqs[i] = lfsr;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (12) @(negedge clk);
    chk(nand_ce_n == 2'b11 && nand_we_n && !req_ready, "R1 reset state", nand_ce_n, 3);
    rb_q = 2'b11; hold = 0;
    for (int i = 0; i < NREQ; i++) begin
      req_page = reqs[i]; req_valid = 1;
      do @(negedge clk); while (!req_ready);
      cur_page = reqs[i];
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
    end
    while (cpl_cnt < NREQ || pos[0] != 0 || pos[1] != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(frames == NREQ, "R3 frame count", frames, NREQ);
    chk(cpl_cnt == NREQ, "R8 completion count", cpl_cnt, NREQ);
    chk(overlap > 0, "R5 overlapped loading", overlap, 1);
    chk(rst_cnt == 2, "R1 reset commands", rst_cnt, 2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule